// File: doc/BRIEF.md
# FM Stereo Multiplex Generator

This block builds the composite baseband that drives a frequency modulator carrying stereo audio. It takes one left and one right 16-bit audio sample per input strobe, at a nominal 44.1 kHz. It runs three update slots per input sample, which gives a 132.3 kHz multiplex rate. In each slot it produces one signed 32-bit multiplex sample. That sample is made of three parts:

- the mono sum L+R in the upper half-word;
- the difference L−R, double-sideband suppressed-carrier modulated onto a 38 kHz subcarrier;
- a 19 kHz pilot at about 9 % of full scale.

Two 16-bit phase accumulators generate the carriers. They start together from zero, and the subcarrier step is exactly twice the pilot step, so the two carriers stay phase locked. The first slot of a group coincides with the input strobe. The other two follow after a programmable cycle count, normally the system clock divided by 132.3 kHz. Each sample is computed one slot ahead and released at the start of the next slot, so the output timing does not depend on when the arithmetic finishes. A sticky flag reports any arithmetic overflow until it is cleared.

Top module: `fm_mpx_gen`

## Requirements
- R1: Each input strobe starts a group of exactly three slots. The first slot falls in the strobe's own clock cycle and the others fall `slot_period` and 2·`slot_period` cycles later (`slot_period` ≥ 2). No further slot occurs until the next strobe.
- R2: A strobe that arrives while a group is still running restarts the group: the old pending slots are dropped and the new group is timed from the new strobe.
- R3: Both phase accumulators are 16 bits wide and clear to zero on reset. On every slot the pilot accumulator advances by 0x24C4 and the subcarrier accumulator by 0x4988, before that slot's sample is computed. The subcarrier phase therefore always equals twice the pilot phase, modulo 2^16.
- R4: The sine of a phase is round(32767·sin(2π·k/1024)), where k is phase bits [15:6]. Rounding is applied to the magnitude, so negative values mirror the positive ones.
- R5: A sample equals sat32(S·2^16 + 2·D·sin38 + 2·2949·sin19). Here S = sat16(L+R) and D = sat16(L−R), the inputs are two's complement, and sat clamps to the signed range of the stated width.
- R6: A sample computed in one slot is driven on `mpx_out` at the next slot, together with a one-cycle `mpx_valid` pulse. The first slot after reset emits 0. `mpx_out` holds its value between slots.
- R7: `overdrive` rises when L+R, L−R or the accumulated sample overflows, and it stays high.
- R8: `ovd_clear` drops `overdrive` on the next clock edge. A new overflow in that same cycle keeps it high.
- R9: After reset, `mpx_out` is 0, `mpx_valid` is 0 and `overdrive` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | Audio sample strobe, one cycle |
| left_in | input | 16 | Left sample, signed |
| right_in | input | 16 | Right sample, signed |
| slot_period | input | 16 | Clock cycles between slots (≥ 2) |
| ovd_clear | input | 1 | Clears the overdrive flag |
| mpx_out | output | 32 | Multiplex sample, signed |
| mpx_valid | output | 1 | One-cycle pulse per slot |
| overdrive | output | 1 | Sticky overflow indicator |

## Verification
The hardest case to reach is a strobe that lands part-way through a running group, because it depends on the position of the slot timer. The bench places a second strobe a few cycles after the first extra slot. It then checks cycle by cycle that the stale third slot never appears and that the new three-slot group is timed from the second strobe. The overflow corners are reached from the sample table: full-scale equal inputs saturate the sum, and the pilot term pushes the accumulated sample past 32 bits.

// File: rtl/fm_mpx_gen.sv
module fm_mpx_gen #(
  parameter int PH_W    = 16,
  parameter int IDX_W   = 10,
  parameter logic [15:0] STEP19 = 16'h24C4,
  parameter logic signed [15:0] PILOT_GAIN = 16'sh0B85
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_valid,
  input  logic signed [15:0] left_in,
  input  logic signed [15:0] right_in,
  input  logic        [15:0] slot_period,
  input  logic               ovd_clear,
  output logic signed [31:0] mpx_out,
  output logic               mpx_valid,
  output logic               overdrive
);
  localparam int Q_W   = IDX_W - 2;
  localparam int Q_N   = 1 << Q_W;
  localparam int ACC_W = 35;
  localparam real HALF_PI = 1.5707963267948966;
  localparam logic [PH_W-1:0] STEP38 = PH_W'(STEP19 << 1);

  logic [14:0] qtab [Q_N];
  for (genvar i = 0; i < Q_N; i++) begin : g_qtab
    localparam real A = 32767.0 * $sin(HALF_PI * i / Q_N);
    localparam int  V = int'($floor(A + 0.5));
    assign qtab[i] = 15'(V);
  end

  function automatic logic signed [15:0] sine(input logic [IDX_W-1:0] k);
    logic [Q_W-1:0] idx;
    logic [14:0] mag;
    idx = k[Q_W-1:0];
    if (k[Q_W] && idx == '0)  mag = 15'h7FFF;
    else if (k[Q_W])          mag = qtab[Q_W'(Q_N - int'(idx))];
    else                      mag = qtab[idx];
    return k[IDX_W-1] ? -$signed({1'b0, mag}) : $signed({1'b0, mag});
  endfunction

  logic [1:0]  left_slots;
  logic [15:0] tcnt;
  logic        slot, calc;
  logic [PH_W-1:0] ph19, ph38;
  logic signed [15:0] lreg, rreg;
  logic signed [31:0] pend;

  assign slot = smp_valid | (left_slots != 2'd0 && tcnt == slot_period - 16'd1);

  // a strobe is itself the first of the three slots, so two remain after it
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      left_slots <= '0;
      tcnt       <= '0;
    end else if (smp_valid) begin
      left_slots <= 2'd2;
      tcnt       <= '0;
    end else if (left_slots != 2'd0) begin
      if (tcnt == slot_period - 16'd1) begin
        tcnt       <= '0;
        left_slots <= left_slots - 2'd1;
      end else
        tcnt <= tcnt + 16'd1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ph19 <= '0; ph38 <= '0;
      lreg <= '0; rreg <= '0;
      mpx_out <= '0; mpx_valid <= 1'b0; calc <= 1'b0;
    end else begin
      mpx_valid <= slot;
      calc      <= slot;
      if (smp_valid) begin
        lreg <= left_in;
        rreg <= right_in;
      end
      if (slot) begin
        mpx_out <= pend;
        ph19    <= ph19 + STEP19;
        ph38    <= ph38 + STEP38;
      end
    end

  logic signed [16:0] sum17, dif17;
  logic signed [15:0] s16, d16, s19, s38;
  logic signed [31:0] p38, p19;
  logic signed [ACC_W-1:0] acc;
  logic ovf_s, ovf_d, ovf_a;

  assign sum17 = 17'(lreg) + 17'(rreg);
  assign dif17 = 17'(lreg) - 17'(rreg);
  assign ovf_s = sum17[16] ^ sum17[15];
  assign ovf_d = dif17[16] ^ dif17[15];
  assign s16 = ovf_s ? (sum17[16] ? 16'sh8000 : 16'sh7FFF) : sum17[15:0];
  assign d16 = ovf_d ? (dif17[16] ? 16'sh8000 : 16'sh7FFF) : dif17[15:0];
  assign s19 = sine(ph19[PH_W-1 -: IDX_W]);
  assign s38 = sine(ph38[PH_W-1 -: IDX_W]);
  assign p38 = d16 * s38;
  assign p19 = PILOT_GAIN * s19;
  assign acc = ACC_W'($signed({s16, 16'h0000})) + (ACC_W'(p38) <<< 1) + (ACC_W'(p19) <<< 1);
  assign ovf_a = !(acc[ACC_W-1:31] == '0 || acc[ACC_W-1:31] == '1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend      <= '0;
      overdrive <= 1'b0;
    end else begin
      if (calc)
        pend <= ovf_a ? (acc[ACC_W-1] ? 32'sh8000_0000 : 32'sh7FFF_FFFF) : acc[31:0];
      overdrive <= (overdrive & ~ovd_clear) | (calc & (ovf_s | ovf_d | ovf_a));
    end

  // R1
  slots_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) left_slots != 2'd3);
  // R1
  strobe_slot_chk: assert property (@(posedge clk) disable iff (!rst_n) smp_valid |=> mpx_valid);
  // R3
  phase_lock_chk: assert property (@(posedge clk) disable iff (!rst_n) ph38 == PH_W'(ph19 << 1));
  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !mpx_valid |-> $stable(mpx_out));
  // R7
  ovd_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) (overdrive && !ovd_clear) |=> overdrive);
endmodule

// File: tb/tb_fm_mpx_gen.sv
module tb_fm_mpx_gen;
  localparam int CLK_PERIOD = 10;
  localparam int P = 8;
  localparam int NV = 6;
  localparam logic [31:0] VEC [NV] = '{
    {16'sd0,     16'sd0},
    {16'sd1000,  -16'sd500},
    {16'sd32767, 16'sd32767},
    {-16'sd20000, 16'sd20000},
    {16'sd12000, 16'sd3000},
    {-16'sd32768, -16'sd32768}
  };

  logic clk = 0, rst_n = 0, smp_valid = 0, ovd_clear = 0;
  logic signed [15:0] left_in = 0, right_in = 0;
  logic [15:0] slot_period = 16'(P);
  logic signed [31:0] mpx_out;
  logic mpx_valid, overdrive;

  int checks = 0, errors = 0;
  bit done = 0;
  logic signed [15:0] cur_l = 0, cur_r = 0;
  logic [15:0] m_ph = 0;
  longint exp_pend = 0;
  bit exp_ovd = 0;

  fm_mpx_gen dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic longint sinq(input logic [15:0] ph);
    int k; real x; longint m;
    k = int'(ph[15:6]);
    x = 32767.0 * $sin(2.0 * 3.141592653589793 * k / 1024.0);
    m = longint'($floor((x < 0 ? -x : x) + 0.5));
    return x < 0 ? -m : m;
  endfunction

  function automatic longint sat(input longint v, input longint lim, output bit o);
    o = (v > lim - 1) || (v < -lim);
    return v > lim - 1 ? lim - 1 : (v < -lim ? -lim : v);
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // model of the sample pipeline, advanced on every observed slot
  always @(negedge clk) if (rst_n && mpx_valid) begin
    longint s, d, a;
    bit o1, o2, o3;
    check(mpx_out == 32'(exp_pend), "R3 R4 R5 R6 sample", mpx_out, exp_pend);
    m_ph = m_ph + 16'h24C4;
    s = sat(longint'(cur_l) + longint'(cur_r), 32768, o1);
    d = sat(longint'(cur_l) - longint'(cur_r), 32768, o2);
    a = s * 65536 + 2 * d * sinq(16'(m_ph << 1)) + 2 * 2949 * sinq(m_ph);
    exp_pend = sat(a, 64'sd2147483648, o3);
    if (o1 || o2 || o3) exp_ovd = 1;
  end

  task automatic strobe(input logic signed [15:0] l, input logic signed [15:0] r);
    cur_l = l; cur_r = r;
    left_in = l; right_in = r; smp_valid = 1;
    @(negedge clk) smp_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset values
    check(mpx_out == 0, "R9 mpx_out", mpx_out, 0);
    check(mpx_valid == 0, "R9 mpx_valid", mpx_valid, 0);
    check(overdrive == 0, "R9 overdrive", overdrive, 0);
    rst_n = 1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      strobe(VEC[v][31:16], VEC[v][15:0]);
      for (int off = 0; off < 4 * P; off++) begin
        bit want;
        if (off > 0) @(negedge clk);
        want = (off % P == 0) && (off < 3 * P);
        // R1 three slots per strobe
        check(mpx_valid == want, "R1 slot timing", mpx_valid, want);
      end
      // R7 sticky flag against model
      check(overdrive == exp_ovd, "R7 overdrive", overdrive, exp_ovd);
      if (exp_ovd) begin
        repeat (5) @(negedge clk);
        check(overdrive == 1, "R7 still set", overdrive, 1);
        ovd_clear = 1;
        @(negedge clk) ovd_clear = 0;
        exp_ovd = 0;
        // R8 manual clear
        check(overdrive == 0, "R8 cleared", overdrive, 0);
      end
    end

    // R2 strobe in the middle of a group realigns the timer
    strobe(16'sd100, 16'sd50);
    for (int off = 0; off < 5 * P; off++) begin
      bit want;
      if (off > 0) @(negedge clk);
      if (off == P + 2) begin
        cur_l = -16'sd700; cur_r = 16'sd300;
        left_in = cur_l; right_in = cur_r; smp_valid = 1;
      end else
        smp_valid = 0;
      want = (off == 0) || (off == P) ||
             (off >= P + 3 && (off - (P + 3)) % P == 0 && off - (P + 3) < 3 * P);
      check(mpx_valid == want, "R2 realign", mpx_valid, want);
    end

    // R8 a fresh overflow wins over a simultaneous clear
    strobe(16'sd32767, 16'sd32767);
    ovd_clear = 1;
    @(negedge clk) ovd_clear = 0;
    check(overdrive == 1, "R8 set wins", overdrive, 1);
    ovd_clear = 1;
    @(negedge clk) ovd_clear = 0;
    exp_ovd = 0;
    repeat (3 * P) @(negedge clk);
    check(overdrive == exp_ovd, "R7 R8 after clear", overdrive, exp_ovd);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule